// File: doc/BRIEF.md
# Vector store lane distribution unit

This unit turns one store request from an 8-lane vector datapath into the memory write operations that carry it out. A request supplies the lane data from one source register, or from two source registers for the pairing pattern. It also supplies a base byte address, an element size, a distribution pattern and an optional per-lane predicate. The unit places each lane's element at an address fixed by the pattern. It truncates the element to its size and drives a byte-enable mask for each write.

The unit has sixteen write slots, because the pairing pattern emits sixteen elements at once. Every pattern except the index-driven one completes in a single cycle. The index-driven pattern takes each lane's offset from an index vector and issues one write per cycle. It holds `busy` while it works and accepts no new request in that time. Disabled lanes leave holes in memory and do not compact the layout.

Top module: `vst_scatter`

## Requirements
- R1: While reset is held and after it is released, no slot writes and `busy` is low.
- R2: An accepted request drives its writes during the cycle after the accepting clock edge, for one cycle. `req_valid` counts only when `busy` is low. Pattern code 0 (all lanes): slot i writes lane i of source A at element offset i.
- R3: Pattern code 1 (single point): only slot 0 writes, with lane 0 of source A at offset 0.
- R4: Pattern code 2 (halving): even lanes 0, 2, 4, 6 write on slots 0, 2, 4, 6 to offsets 0, 1, 2, 3. Odd slots never write.
- R5: Pattern code 3 (pairing): slot 2i writes lane i of source A at offset 2i, and slot 2i+1 writes lane i of source B at offset 2i+1. The predicate of lane i gates both.
- R6: Pattern code 4 (stride nine) writes lane i on slot i at offset 9i. Pattern code 5 (skip one) writes lane i on slot i at offset 2i.
- R7: Size codes are 0 (1 byte), 1 (2 bytes) and 2 (4 bytes). The byte address is base plus offset times size, modulo 2^AW. The data holds the low bytes of the element with its upper bytes zero. Byte enable bit b is set for each byte b below the size.
- R8: A lane is enabled when `req_pred_use` is 0, or when its predicate word is nonzero. A disabled lane suppresses only its own writes, and every other lane keeps its pattern address.
- R9: Pattern code 6 (index-driven) writes enabled lanes in ascending lane order, one per cycle on slot 0 only. Each write carries source A data at offset equal to the low IW bits of that lane's index. With n enabled lanes, `busy` is high for the n cycles after acceptance. The j-th write appears j cycles after the cycle following acceptance.
- R10: An index-driven request with no enabled lane raises no `busy` and produces no write.
- R11: A request presented while `busy` is high is ignored and produces no write.
- R12: Size code 3 or pattern code 7 produces no write and no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request present |
| req_mode | input | 3 | Distribution pattern code |
| req_size | input | 2 | Element size code |
| req_base | input | AW | Base byte address |
| req_pred_use | input | 1 | Apply per-lane predicate |
| req_pred | input | LANES*DW | Predicate word per lane, nonzero = enabled |
| req_data_a | input | LANES*DW | Source register A, lane i at bits i*DW |
| req_data_b | input | LANES*DW | Source register B for pairing |
| req_index | input | LANES*IW | Element offsets for index-driven pattern |
| busy | output | 1 | Index-driven issue in progress |
| wr_en | output | 2*LANES | Per-slot write strobe |
| wr_addr | output | 2*LANES*AW | Per-slot byte address |
| wr_data | output | 2*LANES*DW | Per-slot truncated data |
| wr_be | output | 2*LANES*DW/8 | Per-slot byte enables |

## Verification
The bench targets the index-driven sequencer. It sends requests with all lanes off, with all lanes on and with scattered enables, and it checks that `busy` lasts exactly as many cycles as there are enabled lanes. A sequencer that is off by one would show a missing or duplicated write, or a request dropped after the busy period. An intruding request is presented mid-sequence: a design that let it through would show writes on slots other than 0. Base addresses near the top of the address space catch a design that does not wrap. A single disabled lane among enabled ones catches a design that compacts the layout rather than leaving a hole.

// File: rtl/vst_pkg.sv
package vst_pkg;

  typedef enum logic [2:0] {
    DM_ALL     = 3'd0,
    DM_ONE     = 3'd1,
    DM_HALF    = 3'd2,
    DM_PAIR    = 3'd3,
    DM_STRIDE9 = 3'd4,
    DM_SKIP2   = 3'd5,
    DM_INDEX   = 3'd6,
    DM_NONE    = 3'd7
  } dist_e;

  localparam logic [1:0] SZ_BAD = 2'd3;

endpackage

// File: rtl/vst_lane_map.sv
module vst_lane_map
  import vst_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 32,
  parameter int OW    = 8
) (
  input  dist_e                   mode,
  input  logic [LANES-1:0]        lane_on,
  input  logic [LANES*DW-1:0]     src_a,
  input  logic [LANES*DW-1:0]     src_b,
  output logic [2*LANES-1:0]      slot_en,
  output logic [2*LANES*OW-1:0]   slot_off,
  output logic [2*LANES*DW-1:0]   slot_data
);

  localparam int SLOTS = 2 * LANES;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int LP      = k / 2;
    localparam int LD      = (k < LANES) ? k : 0;
    localparam bit IS_LANE = (k < LANES);
    localparam bit EVEN    = ((k % 2) == 0);

    logic          en_k;
    logic [OW-1:0] off_k;
    logic [DW-1:0] dat_k;

    always_comb begin
      en_k  = 1'b0;
      off_k = '0;
      dat_k = src_a[LD*DW +: DW];
      case (mode)
        DM_ALL: begin
          en_k  = IS_LANE && lane_on[LD];
          off_k = OW'(k);
        end
        DM_ONE: begin
          en_k  = (k == 0) && lane_on[0];
          off_k = '0;
        end
        DM_HALF: begin
          en_k  = IS_LANE && EVEN && lane_on[LD];
          off_k = OW'(k / 2);
        end
        DM_PAIR: begin
          en_k  = lane_on[LP];
          off_k = OW'(k);
          dat_k = EVEN ? src_a[LP*DW +: DW] : src_b[LP*DW +: DW];
        end
        DM_STRIDE9: begin
          en_k  = IS_LANE && lane_on[LD];
          off_k = OW'(9 * k);
        end
        DM_SKIP2: begin
          en_k  = IS_LANE && lane_on[LD];
          off_k = OW'(2 * k);
        end
        default: en_k = 1'b0;
      endcase
    end

    assign slot_en[k]              = en_k;
    assign slot_off[k*OW +: OW]    = off_k;
    assign slot_data[k*DW +: DW]   = dat_k;
  end

endmodule

// File: rtl/vst_index_seq.sv
module vst_index_seq #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  parameter int IW    = 8,
  parameter int AW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LANES-1:0]      lane_on,
  input  logic [LANES*DW-1:0]   src_a,
  input  logic [LANES*IW-1:0]   index,
  input  logic [AW-1:0]         base,
  input  logic [1:0]            size,
  output logic                  active,
  output logic [IW-1:0]         out_off,
  output logic [DW-1:0]         out_data,
  output logic [AW-1:0]         out_base,
  output logic [1:0]            out_size
);

  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0]    mask_q, mask_d, pick_oh;
  logic [LW-1:0]       pick_sel;
  logic                found;
  logic [LANES*DW-1:0] data_q;
  logic [LANES*IW-1:0] idx_q;
  logic [AW-1:0]       base_q;
  logic [1:0]          size_q;

  // lowest remaining lane goes first
  always_comb begin
    pick_oh  = '0;
    pick_sel = '0;
    found    = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (mask_q[i] && !found) begin
        found       = 1'b1;
        pick_oh[i]  = 1'b1;
        pick_sel    = LW'(i);
      end
    end
  end

  always_comb begin
    mask_d = start ? lane_on : (mask_q & ~pick_oh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      data_q <= src_a;
      idx_q  <= index;
      base_q <= base;
      size_q <= size;
    end
  end

  assign active   = |mask_q;
  assign out_off  = idx_q[pick_sel*IW +: IW];
  assign out_data = data_q[pick_sel*DW +: DW];
  assign out_base = base_q;
  assign out_size = size_q;

endmodule

// File: rtl/vst_slot_fmt.sv
module vst_slot_fmt #(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [OW-1:0]     off,
  input  logic [DW-1:0]     data,
  input  logic [AW-1:0]     base,
  input  logic [1:0]        size,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     data_o,
  output logic [DW/8-1:0]   be
);

  localparam int BEW = DW / 8;

  always_comb begin
    addr = base + (AW'(off) << size);
    for (int b = 0; b < BEW; b++) begin
      be[b]            = (b < (1 << size));
      data_o[b*8 +: 8] = (b < (1 << size)) ? data[b*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/vst_scatter.sv
module vst_scatter
  import vst_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int IW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [2:0]                    req_mode,
  input  logic [1:0]                    req_size,
  input  logic [AW-1:0]                 req_base,
  input  logic                          req_pred_use,
  input  logic [LANES*DW-1:0]           req_pred,
  input  logic [LANES*DW-1:0]           req_data_a,
  input  logic [LANES*DW-1:0]           req_data_b,
  input  logic [LANES*IW-1:0]           req_index,
  output logic                          busy,
  output logic [2*LANES-1:0]            wr_en,
  output logic [2*LANES*AW-1:0]         wr_addr,
  output logic [2*LANES*DW-1:0]         wr_data,
  output logic [2*LANES*(DW/8)-1:0]     wr_be
);

  localparam int SLOTS   = 2 * LANES;
  localparam int BEW     = DW / 8;
  localparam int MAP_MAX = (9 * (LANES - 1) > SLOTS - 1) ? 9 * (LANES - 1) : SLOTS - 1;
  localparam int OW_MAP  = $clog2(MAP_MAX + 1);
  localparam int OW      = (OW_MAP > IW) ? OW_MAP : IW;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign core_rst_n = rst_pipe[1];

  // lane enables
  logic [LANES-1:0] lane_on;
  for (genvar i = 0; i < LANES; i++) begin : g_pred
    assign lane_on[i] = !req_pred_use || (|req_pred[i*DW +: DW]);
  end

  dist_e mode_e;
  logic  seq_active, accept, size_ok, start_idx, map_take;

  assign mode_e    = dist_e'(req_mode);
  assign size_ok   = (req_size != SZ_BAD);
  assign accept    = req_valid && !seq_active;
  assign start_idx = accept && size_ok && (mode_e == DM_INDEX);
  assign map_take  = accept && size_ok && (mode_e != DM_INDEX);

  logic [SLOTS-1:0]    map_en;
  logic [SLOTS*OW-1:0] map_off;
  logic [SLOTS*DW-1:0] map_data;

  vst_lane_map #(.LANES(LANES), .DW(DW), .OW(OW)) u_map (
    .mode      (mode_e),
    .lane_on   (lane_on),
    .src_a     (req_data_a),
    .src_b     (req_data_b),
    .slot_en   (map_en),
    .slot_off  (map_off),
    .slot_data (map_data)
  );

  logic [IW-1:0] seq_off;
  logic [DW-1:0] seq_data;
  logic [AW-1:0] seq_base;
  logic [1:0]    seq_size;

  vst_index_seq #(.LANES(LANES), .DW(DW), .IW(IW), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start    (start_idx),
    .lane_on  (lane_on),
    .src_a    (req_data_a),
    .index    (req_index),
    .base     (req_base),
    .size     (req_size),
    .active   (seq_active),
    .out_off  (seq_off),
    .out_data (seq_data),
    .out_base (seq_base),
    .out_size (seq_size)
  );

  // next-state selection
  logic [SLOTS-1:0]     en_d;
  logic [SLOTS*OW-1:0]  off_d;
  logic [SLOTS*DW-1:0]  dat_d;
  logic [AW-1:0]        sel_base;
  logic [1:0]           sel_size;

  always_comb begin
    sel_base = seq_active ? seq_base : req_base;
    sel_size = seq_active ? seq_size : req_size;
    en_d     = '0;
    off_d    = map_off;
    dat_d    = map_data;
    if (seq_active) begin
      en_d[0]        = 1'b1;
      off_d[OW-1:0]  = OW'(seq_off);
      dat_d[DW-1:0]  = seq_data;
    end else if (map_take) begin
      en_d = map_en;
    end
  end

  logic [SLOTS*AW-1:0]  addr_d;
  logic [SLOTS*DW-1:0]  dat_f;
  logic [SLOTS*BEW-1:0] be_d;

  for (genvar k = 0; k < SLOTS; k++) begin : g_fmt
    vst_slot_fmt #(.DW(DW), .AW(AW), .OW(OW)) u_fmt (
      .off    (off_d[k*OW +: OW]),
      .data   (dat_d[k*DW +: DW]),
      .base   (sel_base),
      .size   (sel_size),
      .addr   (addr_d[k*AW +: AW]),
      .data_o (dat_f[k*DW +: DW]),
      .be     (be_d[k*BEW +: BEW])
    );
  end

  // output registers
  logic [SLOTS-1:0]     en_q;
  logic [SLOTS*AW-1:0]  addr_q;
  logic [SLOTS*DW-1:0]  data_q;
  logic [SLOTS*BEW-1:0] be_q;
  logic                 pay_ce;

  assign pay_ce = |en_d;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pay_ce) begin
      addr_q <= addr_d;
      data_q <= dat_f;
      be_q   <= be_d;
    end
  end

  assign busy    = seq_active;
  assign wr_en   = en_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign wr_be   = be_q;

endmodule

// File: rtl/vst_scatter_chk.sv
module vst_scatter_chk #(
  parameter int LANES = 8,
  parameter int DW    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [2:0]                  req_mode,
  input logic [1:0]                  req_size,
  input logic                        busy,
  input logic [2*LANES-1:0]          wr_en,
  input logic [2*LANES*(DW/8)-1:0]   wr_be
);

  localparam int SLOTS = 2 * LANES;
  localparam int BEW   = DW / 8;

  logic take;
  assign take = req_valid && !busy && (req_size != 2'd3) && (req_mode != 3'd7);

  // R9
  idx_one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> (wr_en == SLOTS'(1)));

  // R9
  idx_busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && (req_mode == 3'd6) && (req_size != 2'd3)));

  // R3
  one_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take && (req_mode == 3'd1)) |-> ((wr_en >> 1) == '0));

  // R12
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !busy && ((req_size == 2'd3) || (req_mode == 3'd7))) |-> (wr_en == '0));

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
    if (((k % 2) == 1) || (k >= LANES)) begin : g_odd
      // R4
      half_even_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && (req_mode == 3'd2)) |-> !wr_en[k]);
    end
    // R7
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[k] |-> (wr_be[k*BEW] &&
                    ((wr_be[k*BEW +: BEW] & (wr_be[k*BEW +: BEW] + BEW'(1))) == '0)));
  end

endmodule

bind vst_scatter vst_scatter_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_mode  (req_mode),
  .req_size  (req_size),
  .busy      (busy),
  .wr_en     (wr_en),
  .wr_be     (wr_be)
);

// File: tb/vst_scatter_tb_top.sv
`timescale 1ns/1ps
module vst_scatter_tb_top;

  localparam int LANES = 8;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam int IW    = 8;
  localparam int SLOTS = 2 * LANES;
  localparam int BEW   = DW / 8;

  logic                   clk, rst_n, req_valid, req_pred_use, busy;
  logic [2:0]             req_mode;
  logic [1:0]             req_size;
  logic [AW-1:0]          req_base;
  logic [LANES*DW-1:0]    req_pred, req_data_a, req_data_b;
  logic [LANES*IW-1:0]    req_index;
  logic [SLOTS-1:0]       wr_en;
  logic [SLOTS*AW-1:0]    wr_addr;
  logic [SLOTS*DW-1:0]    wr_data;
  logic [SLOTS*BEW-1:0]   wr_be;

  vst_scatter #(.LANES(LANES), .DW(DW), .AW(AW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_base(req_base), .req_pred_use(req_pred_use),
    .req_pred(req_pred), .req_data_a(req_data_a), .req_data_b(req_data_b),
    .req_index(req_index), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [SLOTS-1:0] x_en;
  logic [AW-1:0]    x_addr [SLOTS];
  logic [DW-1:0]    x_data [SLOTS];
  logic [BEW-1:0]   x_be   [SLOTS];
  int               q_n;
  logic [AW-1:0]    q_addr [LANES];
  logic [DW-1:0]    q_data [LANES];
  logic [BEW-1:0]   q_be;

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  function automatic logic lane_true(int i);
    return !req_pred_use || (req_pred[i*DW +: DW] != '0);
  endfunction

  function automatic logic [DW-1:0] trunc(logic [DW-1:0] d, int nb);
    logic [DW-1:0] m;
    m = (nb >= 4) ? '1 : DW'((64'd1 << (8 * nb)) - 64'd1);
    return d & m;
  endfunction

  function automatic logic [AW-1:0] addr_of(int off, int nb);
    return AW'(int'(req_base) + off * nb);
  endfunction

  function automatic logic [BEW-1:0] be_of(int nb);
    return BEW'((1 << nb) - 1);
  endfunction

  function automatic string req_of(int mode);
    case (mode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(logic ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build_single();
    int nb;
    nb = 1 << int'(req_size);
    for (int k = 0; k < SLOTS; k++) begin
      int off;
      logic e;
      logic [DW-1:0] d;
      e = 1'b0;
      off = 0;
      d = req_data_a[((k < LANES) ? k : 0)*DW +: DW];
      case (int'(req_mode))
        0: if (k < LANES) begin e = lane_true(k); off = k; end
        1: if (k == 0) begin e = lane_true(0); off = 0; end
        2: if (k < LANES && (k % 2) == 0) begin e = lane_true(k); off = k / 2; end
        3: begin
          e = lane_true(k / 2);
          off = k;
          d = (k % 2 == 1) ? req_data_b[(k/2)*DW +: DW] : req_data_a[(k/2)*DW +: DW];
        end
        4: if (k < LANES) begin e = lane_true(k); off = 9 * k; end
        5: if (k < LANES) begin e = lane_true(k); off = 2 * k; end
        default: e = 1'b0;
      endcase
      if (req_size == 2'd3) e = 1'b0;
      x_en[k]   = e;
      x_addr[k] = addr_of(off, nb);
      x_data[k] = trunc(d, nb);
      x_be[k]   = be_of(nb);
    end
  endtask

  task automatic build_index();
    int nb;
    nb = 1 << int'(req_size);
    q_n = 0;
    q_be = be_of(nb);
    for (int l = 0; l < LANES; l++) begin
      if (lane_true(l)) begin
        q_addr[q_n] = addr_of(int'(req_index[l*IW +: IW]), nb);
        q_data[q_n] = trunc(req_data_a[l*DW +: DW], nb);
        q_n++;
      end
    end
  endtask

  task automatic check_slots(string req);
    for (int k = 0; k < SLOTS; k++) begin
      logic ok;
      ok = (wr_en[k] === x_en[k]) &&
           (!x_en[k] || ((wr_addr[k*AW +: AW] === x_addr[k]) &&
                         (wr_data[k*DW +: DW] === x_data[k]) &&
                         (wr_be[k*BEW +: BEW] === x_be[k])));
      check(ok, req, $sformatf("slot %0d {en,be,addr,data}", k),
            {11'd0, wr_en[k], wr_be[k*BEW +: BEW], wr_addr[k*AW +: AW], wr_data[k*DW +: DW]},
            {11'd0, x_en[k], x_be[k], x_addr[k], x_data[k]});
    end
  endtask

  task automatic fill_random();
    for (int l = 0; l < LANES; l++) begin
      req_data_a[l*DW +: DW] = $urandom;
      req_data_b[l*DW +: DW] = $urandom;
      req_pred[l*DW +: DW]   = ($urandom % 4 == 0) ? '0 : ($urandom | 32'd1);
      req_index[l*IW +: IW]  = IW'($urandom);
    end
  endtask

  task automatic run_req(int mode, int size, logic [AW-1:0] base, logic puse, bit intrude, string req);
    bit is_idx;
    @(negedge clk);
    req_mode     = 3'(mode);
    req_size     = 2'(size);
    req_base     = base;
    req_pred_use = puse;
    req_valid    = 1'b1;
    is_idx = (mode == 6) && (size != 3);
    if (is_idx) begin
      build_index();
      x_en = '0;
    end else begin
      build_single();
      q_n = 0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (!is_idx) begin
      check_slots(req);
      check(busy === 1'b0, req, "busy after one-cycle pattern", 64'(busy), 64'd0);
    end else begin
      check(busy === (q_n > 0), req, "busy after accept", 64'(busy), 64'(q_n > 0));
      check(wr_en === '0, req, "no write in accept cycle", 64'(wr_en), 64'd0);
      if (intrude && q_n >= 2) begin
        fill_random();
        req_mode  = 3'd0;
        req_size  = 2'd2;
        req_valid = 1'b1;
      end
      for (int j = 0; j < q_n; j++) begin
        logic ok;
        @(negedge clk);
        req_valid = 1'b0;
        ok = (wr_en === SLOTS'(1)) && (wr_addr[AW-1:0] === q_addr[j]) &&
             (wr_data[DW-1:0] === q_data[j]) && (wr_be[BEW-1:0] === q_be);
        check(ok, intrude ? "R11" : "R9", $sformatf("indexed write %0d {en,addr,data}", j),
              {wr_en, wr_addr[AW-1:0], wr_data[DW-1:0]},
              {16'd1, q_addr[j], q_data[j]});
        check(busy === (j < q_n - 1), "R9", "busy during issue", 64'(busy), 64'(j < q_n - 1));
      end
      @(negedge clk);
      check(wr_en === '0, (q_n == 0) ? "R10" : "R11", "no write after sequence", 64'(wr_en), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_mode = 3'd0;
    req_size = 2'd0;
    req_base = '0;
    req_pred_use = 1'b0;
    req_pred = '0;
    req_data_a = '0;
    req_data_b = '0;
    req_index = '0;
    repeat (3) @(negedge clk);
    check(wr_en === '0 && busy === 1'b0, "R1", "outputs in reset", {wr_en, 47'(busy)}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(wr_en === '0 && busy === 1'b0, "R1", "outputs after reset", {wr_en, 47'(busy)}, 64'd0);

    // R8: holes from disabled lanes
    fill_random();
    req_pred[1*DW +: DW] = '0;
    req_pred[4*DW +: DW] = '0;
    req_pred[0*DW +: DW] = 32'h0000_0100;
    run_req(0, 2, 16'h0100, 1'b1, 1'b0, "R8");
    run_req(3, 1, 16'h0200, 1'b1, 1'b0, "R8");

    // R7: address wrap and sizes
    fill_random();
    run_req(4, 2, 16'hFFF0, 1'b0, 1'b0, "R7");
    run_req(0, 0, 16'h0033, 1'b0, 1'b0, "R7");
    run_req(5, 1, 16'hFFFE, 1'b0, 1'b0, "R7");

    // R10: index pattern with every lane off
    fill_random();
    req_pred = '0;
    run_req(6, 2, 16'h0400, 1'b1, 1'b0, "R10");

    // R9: all lanes, repeated indices
    fill_random();
    req_index[2*IW +: IW] = req_index[5*IW +: IW];
    run_req(6, 1, 16'h0800, 1'b0, 1'b0, "R9");

    // R11: request offered mid-sequence
    fill_random();
    run_req(6, 2, 16'h0C00, 1'b0, 1'b1, "R11");

    // R12: reserved codes
    fill_random();
    run_req(0, 3, 16'h0010, 1'b0, 1'b0, "R12");
    run_req(7, 2, 16'h0010, 1'b0, 1'b0, "R12");
    run_req(6, 3, 16'h0010, 1'b0, 1'b0, "R12");

    // R3, R4, R5, R6 directed
    fill_random();
    run_req(1, 2, 16'h0020, 1'b0, 1'b0, "R3");
    run_req(2, 0, 16'h0030, 1'b0, 1'b0, "R4");
    run_req(3, 2, 16'h0040, 1'b0, 1'b0, "R5");
    run_req(4, 0, 16'h0050, 1'b0, 1'b0, "R6");
    run_req(5, 2, 16'h0060, 1'b0, 1'b0, "R6");

    for (int t = 0; t < 300; t++) begin
      int m;
      fill_random();
      m = int'($urandom % 7);
      run_req(m, int'($urandom % 3), AW'($urandom), logic'($urandom % 2),
              bit'($urandom % 2), req_of(m));
    end

    finish_run();
  end

endmodule